// File: doc/BRIEF.md
# Waterfall Uniform-Index Serializer

A vector unit often holds a register index that differs from lane to lane, while the scalar side that drives a relative register access can only use one index at a time. This block turns such a divergent index into a short series of passes. Each pass carries one uniform index and the mask of lanes that hold that index. The lanes still waiting are tracked internally, and a single done strobe closes the series. The access itself is left to the logic that consumes the passes.

On an accepted start the block takes a snapshot of the active mask and of every lane's index. In each following cycle it finds the lowest-numbered lane that is still waiting and takes that lane's index as the uniform value. It collects every waiting lane that holds the same value and drops those lanes from the waiting set. When nothing is left it raises done and presents the saved mask, so the caller can put the original active set back. When the caller marks the index as already scalar, the whole active mask goes out in one pass.

Top module: `wf_serializer`

## Requirements
- R1: After reset, `pass_vld_o` and `done_o` are low and stay low until a start is accepted.
- R2: Each pass carries as `pass_idx_o` the snapshot index of the lowest-numbered lane still waiting. Lane i's index occupies bits [i*IDX_W +: IDX_W] of `lane_idx_i`.
- R3: A pass mask holds exactly the waiting lanes whose snapshot index equals the pass index. It is never empty, and no lane appears in two passes of the same series.
- R4: Passes come on consecutive cycles. The first pass is visible one cycle after the accepting clock edge. The number of passes equals the number of distinct index values among the active lanes.
- R5: `done_o` is high for one cycle, one cycle after the last pass. It is never high together with `pass_vld_o`. While it is high, `restore_mask_o` equals the active mask captured at start.
- R6: With `uniform_i` high at start, exactly one pass is produced. It carries `scalar_idx_i` and the full captured mask, whatever the lane indices are.
- R7: A start with an all-zero active mask produces no pass. Done follows one cycle after the accepting edge, with a zero restore mask.
- R8: A start while a series is running is ignored. The series in progress keeps its passes and its restore mask.
- R9: The block accepts a start presented while `done_o` is high. That series' first pass follows one cycle after that edge.
- R10: A lane that is not in the captured active mask never appears in a pass mask, even when its index matches the pass index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled only when idle |
| uniform_i | input | 1 | Index is already scalar: one pass with `scalar_idx_i` |
| scalar_idx_i | input | IDX_W | Uniform index used when `uniform_i` is high |
| act_mask_i | input | LANES | Active lanes at start |
| lane_idx_i | input | LANES*IDX_W | Per-lane indices, lane i at bits [i*IDX_W +: IDX_W] |
| pass_vld_o | output | 1 | A pass is presented this cycle |
| pass_idx_o | output | IDX_W | Uniform index of the pass |
| pass_mask_o | output | LANES | Lanes served by the pass |
| done_o | output | 1 | Series finished, one-cycle strobe |
| restore_mask_o | output | LANES | Captured active mask, valid with `done_o` |

## Verification
The bench uses the default 64 lanes and 32-bit indices. The full 64-pass series, with every lane distinct, and the pass on the top lane are therefore both reachable. Random indices are drawn from a range of four values, so many lanes collide. Inactive lanes then share an index with active ones, which exercises the masking of R10 and the merging of lanes into a single pass. The widest index keeps the comparators at their full width, while the narrow draw keeps each random series short.

// File: rtl/wf_pkg.sv
package wf_pkg;

    typedef enum logic [0:0] {
        WF_IDLE = 1'b0,
        WF_RUN  = 1'b1
    } wf_state_e;

endpackage

// File: rtl/wf_first_lane.sv
// Lowest-index request finder.
module wf_first_lane #(
    parameter int LANES = 64,
    localparam int POS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] req_i,
    output logic             found_o,
    output logic [POS_W-1:0] pos_o
);

    always_comb begin
        pos_o   = '0;
        found_o = |req_i;
        // Scanning downward leaves the lowest set lane in pos_o.
        for (int i = LANES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                pos_o = POS_W'(i);
            end
        end
    end

endmodule

// File: rtl/wf_lane_select.sv
// Picks one lane's index out of the snapshot.
module wf_lane_select #(
    parameter int LANES = 64,
    parameter int IDX_W = 32,
    localparam int POS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0][IDX_W-1:0] idx_i,
    input  logic [POS_W-1:0]            sel_i,
    output logic [IDX_W-1:0]            idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel_i == POS_W'(i)) begin
                idx_o = idx_i[i];
            end
        end
    end

endmodule

// File: rtl/wf_match.sv
// One comparator per lane against the uniform key, gated by the candidate set.
module wf_match #(
    parameter int LANES = 64,
    parameter int IDX_W = 32
) (
    input  logic [LANES-1:0][IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0]            key_i,
    input  logic [LANES-1:0]            cand_i,
    output logic [LANES-1:0]            hit_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit_o[g] = cand_i[g] && (idx_i[g] == key_i);
    end

endmodule

// File: rtl/wf_serializer.sv
module wf_serializer
    import wf_pkg::*;
#(
    parameter int LANES = 64,
    parameter int IDX_W = 32,
    localparam int POS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic                   uniform_i,
    input  logic [IDX_W-1:0]       scalar_idx_i,
    input  logic [LANES-1:0]       act_mask_i,
    input  logic [LANES*IDX_W-1:0] lane_idx_i,
    output logic                   pass_vld_o,
    output logic [IDX_W-1:0]       pass_idx_o,
    output logic [LANES-1:0]       pass_mask_o,
    output logic                   done_o,
    output logic [LANES-1:0]       restore_mask_o
);

    typedef struct packed {
        wf_state_e                   state;
        logic [LANES-1:0]            rem;
        logic [LANES-1:0]            orig;
        logic [LANES-1:0][IDX_W-1:0] idx;
        logic                        pv;
        logic [IDX_W-1:0]            pidx;
        logic [LANES-1:0]            pmask;
        logic                        done;
    } wf_regs_t;

    wf_regs_t q, d;

    logic                        first_found;
    logic [POS_W-1:0]            first_pos;
    logic [IDX_W-1:0]            key;
    logic [LANES-1:0]            hit;
    logic [LANES-1:0][IDX_W-1:0] in_idx;
    logic                        busy;

    // The flat input is reinterpreted lane by lane.
    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign in_idx[g] = lane_idx_i[g*IDX_W +: IDX_W];
    end

    wf_first_lane #(.LANES(LANES)) u_first (
        .req_i   (q.rem),
        .found_o (first_found),
        .pos_o   (first_pos)
    );

    wf_lane_select #(.LANES(LANES), .IDX_W(IDX_W)) u_sel (
        .idx_i (q.idx),
        .sel_i (first_pos),
        .idx_o (key)
    );

    wf_match #(.LANES(LANES), .IDX_W(IDX_W)) u_match (
        .idx_i  (q.idx),
        .key_i  (key),
        .cand_i (q.rem),
        .hit_o  (hit)
    );

    always_comb begin
        d       = q;
        d.pv    = 1'b0;
        d.done  = 1'b0;
        unique case (q.state)
            WF_IDLE: begin
                if (start_i) begin
                    d.state = WF_RUN;
                    d.orig  = act_mask_i;
                    d.rem   = act_mask_i;
                    // A scalar index is broadcast to every lane, so the match
                    // stage retires all active lanes in one pass.
                    for (int i = 0; i < LANES; i++) begin
                        d.idx[i] = uniform_i ? scalar_idx_i : in_idx[i];
                    end
                end
            end
            WF_RUN: begin
                if (first_found) begin
                    d.pv    = 1'b1;
                    d.pidx  = key;
                    d.pmask = q.orig & hit;
                    d.rem   = q.rem ^ hit;
                end else begin
                    d.done  = 1'b1;
                    d.state = WF_IDLE;
                end
            end
            default: d.state = WF_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy           = (q.state == WF_RUN);
    assign pass_vld_o     = q.pv;
    assign pass_idx_o     = q.pidx;
    assign pass_mask_o    = q.pmask;
    assign done_o         = q.done;
    assign restore_mask_o = q.orig;

endmodule

// File: rtl/wf_serializer_chk.sv
module wf_serializer_chk #(
    parameter int LANES = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             busy_i,
    input logic             start_i,
    input logic [LANES-1:0] act_mask_i,
    input logic             pass_vld_o,
    input logic [LANES-1:0] pass_mask_o,
    input logic             done_o,
    input logic [LANES-1:0] restore_mask_o
);

    // Union of the lanes served since the last accepted start.
    logic [LANES-1:0] served_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            served_q <= '0;
        end else if (!busy_i && start_i) begin
            served_q <= '0;
        end else if (pass_vld_o) begin
            served_q <= served_q | pass_mask_o;
        end
    end

    a_r5_done_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !pass_vld_o);

    a_r3_pass_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_vld_o |-> (pass_mask_o != '0));

    a_r3_pass_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_vld_o |-> ((pass_mask_o & served_q) == '0));

    a_r5_full_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (served_q == restore_mask_o));

    a_r10_inside_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_vld_o |-> ((pass_mask_o & ~restore_mask_o) == '0));

    a_r7_empty_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && start_i && act_mask_i == '0) |=> (!pass_vld_o && !done_o));

    a_r8_mask_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && start_i) |=> $stable(restore_mask_o));

endmodule

bind wf_serializer wf_serializer_chk #(.LANES(LANES)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .busy_i         (busy),
    .start_i        (start_i),
    .act_mask_i     (act_mask_i),
    .pass_vld_o     (pass_vld_o),
    .pass_mask_o    (pass_mask_o),
    .done_o         (done_o),
    .restore_mask_o (restore_mask_o)
);

// File: tb/wf_serializer_tb_top.sv
module wf_serializer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 64;
    localparam int IDX_W      = 32;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        start = 1'b0;
    logic                        uni = 1'b0;
    logic [IDX_W-1:0]            sidx = '0;
    logic [LANES-1:0]            mask = '0;
    logic [LANES-1:0][IDX_W-1:0] stim_idx = '0;
    logic                        pass_vld_o;
    logic [IDX_W-1:0]            pass_idx_o;
    logic [LANES-1:0]            pass_mask_o;
    logic                        done_o;
    logic [LANES-1:0]            restore_mask_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    wf_serializer #(.LANES(LANES), .IDX_W(IDX_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .start_i        (start),
        .uniform_i      (uni),
        .scalar_idx_i   (sidx),
        .act_mask_i     (mask),
        .lane_idx_i     (stim_idx),
        .pass_vld_o     (pass_vld_o),
        .pass_idx_o     (pass_idx_o),
        .pass_mask_o    (pass_mask_o),
        .done_o         (done_o),
        .restore_mask_o (restore_mask_o)
    );

    typedef struct {
        logic [IDX_W-1:0] idx;
        logic [LANES-1:0] msk;
        int               cyc;
    } pass_t;

    typedef struct {
        logic [LANES-1:0] msk;
        int               cyc;
    } done_t;

    pass_t exp_p[$];
    done_t exp_d[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    over = 1'b0;
    string tag = "R1";

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what,
                         input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL [%s] %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && !over) begin
            if (pass_vld_o) begin
                if (exp_p.size() == 0) begin
                    check(1'b0, "R4 unexpected pass", pass_mask_o, '0);
                end else begin
                    pass_t e;
                    e = exp_p.pop_front();
                    check(pass_idx_o == e.idx, "R2 pass index", 64'(pass_idx_o), 64'(e.idx));
                    check(pass_mask_o == e.msk, "R3 pass mask", pass_mask_o, e.msk);
                    check(cyc == e.cyc, "R4 pass cycle", 64'(cyc), 64'(e.cyc));
                end
            end
            if (done_o) begin
                check(!pass_vld_o, "R5 done with pass", 64'(pass_vld_o), 64'd0);
                check(exp_p.size() == 0, "R4 passes left at done", 64'(exp_p.size()), 64'd0);
                if (exp_d.size() == 0) begin
                    check(1'b0, "R5 unexpected done", restore_mask_o, '0);
                end else begin
                    done_t e;
                    e = exp_d.pop_front();
                    check(restore_mask_o == e.msk, "R5 restore mask", restore_mask_o, e.msk);
                    check(cyc == e.cyc, "R5 done cycle", 64'(cyc), 64'(e.cyc));
                end
            end
        end
    end

    // Driver: presents a start, then pushes the expected series from a model.
    task automatic run_seq(input string t, input logic [LANES-1:0] m,
                           input logic [LANES-1:0][IDX_W-1:0] ix,
                           input bit u, input logic [IDX_W-1:0] s,
                           input bit b2b, input bit poke);
        logic [LANES-1:0] rem;
        int               acc;
        int               k;
        if (!b2b) @(negedge clk);
        tag = t;
        start = 1'b1; mask = m; stim_idx = ix; uni = u; sidx = s;
        @(posedge clk);
        #1;
        acc = cyc;
        rem = m;
        k = 0;
        if (u) begin
            if (m != '0) begin
                k = 1;
                exp_p.push_back('{idx: s, msk: m, cyc: acc + 1});
            end
        end else begin
            while (rem != '0) begin
                logic [IDX_W-1:0] key;
                logic [LANES-1:0] hit;
                key = '0;
                for (int i = LANES - 1; i >= 0; i--) if (rem[i]) key = ix[i];
                hit = '0;
                for (int j = 0; j < LANES; j++) if (rem[j] && ix[j] == key) hit[j] = 1'b1;
                k++;
                exp_p.push_back('{idx: key, msk: hit, cyc: acc + k});
                rem = rem & ~hit;
            end
        end
        exp_d.push_back('{msk: m, cyc: acc + k + 1});
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R8: a second start mid-series with other data must be ignored.
            repeat (4) @(negedge clk);
            start = 1'b1; mask = ~m; stim_idx = '0; uni = 1'b1; sidx = 32'hDEAD;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_o) @(negedge clk);
    endtask

    function automatic logic [LANES-1:0][IDX_W-1:0] rand_idx(input int range);
        logic [LANES-1:0][IDX_W-1:0] r;
        for (int i = 0; i < LANES; i++) r[i] = IDX_W'($urandom_range(range - 1, 0));
        return r;
    endfunction

    initial begin
        logic [LANES-1:0][IDX_W-1:0] ix;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: outputs quiet after reset.
        repeat (3) begin
            @(negedge clk);
            check(!pass_vld_o && !done_o, "R1 idle outputs", {pass_vld_o, done_o}, '0);
        end
        // R2 R3: colliding indices, random mask.
        ix = rand_idx(4);
        run_seq("R2/R3 random", {$urandom, $urandom}, ix, 1'b0, '0, 1'b0, 1'b0);
        // R4: every lane distinct, 64 passes; R8 poke inside.
        for (int i = 0; i < LANES; i++) ix[i] = IDX_W'(1000 - i);
        run_seq("R4 R8 distinct", '1, ix, 1'b0, '0, 1'b0, 1'b1);
        // All lanes equal: a single pass.
        for (int i = 0; i < LANES; i++) ix[i] = 32'h0000_0007;
        run_seq("R4 single", '1, ix, 1'b0, '0, 1'b0, 1'b0);
        // R10: inactive lanes share the key with active ones.
        for (int i = 0; i < LANES; i++) ix[i] = IDX_W'(i % 3);
        run_seq("R10 sparse", 64'h0000_0F00_0000_0021, ix, 1'b0, '0, 1'b0, 1'b0);
        // Only the top lane active.
        ix = rand_idx(1 << 16);
        run_seq("R2 top lane", 64'h8000_0000_0000_0000, ix, 1'b0, '0, 1'b0, 1'b0);
        // R6: scalar index, lane indices all different.
        for (int i = 0; i < LANES; i++) ix[i] = IDX_W'(i);
        run_seq("R6 uniform", 64'hFFFF_0000_1234_5678, ix, 1'b1, 32'hCAFE_0001, 1'b0, 1'b0);
        // R7: empty mask, both modes.
        run_seq("R7 empty", '0, ix, 1'b0, '0, 1'b0, 1'b0);
        run_seq("R7 empty uniform", '0, ix, 1'b1, 32'h5, 1'b0, 1'b0);
        // R9: start presented in the done cycle.
        ix = rand_idx(3);
        run_seq("R9 first", 64'hF0F0_F0F0_0F0F_0F0F, ix, 1'b0, '0, 1'b0, 1'b0);
        run_seq("R9 back-to-back", 64'h00FF_00FF_FF00_FF00, rand_idx(3), 1'b0, '0, 1'b1, 1'b0);
        run_seq("R9 back-to-back empty", '0, ix, 1'b0, '0, 1'b1, 1'b0);
        // Random sweep over R2 R3 R4 R5.
        for (int n = 0; n < 20; n++) begin
            run_seq("R5 sweep", {$urandom, $urandom}, rand_idx(4), 1'b0, '0, n[0], 1'b0);
        end
        repeat (4) @(negedge clk);
        tag = "R4 end";
        check(exp_p.size() == 0, "R4 missing passes", 64'(exp_p.size()), 64'd0);
        check(exp_d.size() == 0, "R5 missing done", 64'(exp_d.size()), 64'd0);
        if (!over) begin
            over = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!over) begin
            over = 1'b1;
            checks++;
            errors++;
            $display("FAIL [watchdog] run did not finish got %0d exp %0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule